// File: doc/BRIEF.md
# Coin-Accumulating Vending Controller

This block keeps the running credit for a single purchase at a fixed price of 20 units. A coin acceptor upstream presents one already-validated coin per clock cycle as a 2-bit code qualified by a strobe. Three denominations are recognised: 5, 10 and 25 units. The credit is held internally as a count of 5-unit steps and can only be 0, 5, 10 or 15 units. A credit of 20 or more is never stored.

The outputs are Mealy outputs. In the same cycle as the coin that brings the total to 20 or more, the block raises a one-cycle vend pulse and presents the amount to return, counted in 5-unit steps. At the next clock edge it drops back to zero credit, ready for the next customer. The largest return occurs when 15 units are held and a 25-unit coin arrives, which gives 20 units back.

The reset input is asynchronous and active low. Internally it is released in step with the clock, so coins are accepted again only after two clock edges.

Top module: `coin_vend_fsm`

## Requirements
- R1: While `rst_n_i` is low, `vend_o` is 0 and `change_o` is 0 whatever coin is presented, and the credit is forced to zero.
- R2: Coin code 2'b01 is worth 5 units, 2'b10 is worth 10 units and 2'b11 is worth 25 units. Code 2'b00 with the strobe high adds nothing and never vends.
- R3: The credit changes only in a cycle where `coin_valid_i` is high. A coin code presented with the strobe low is ignored.
- R4: While credit plus coin stays below 20 units, `vend_o` stays 0 and the sum is held as the new credit at the next rising edge.
- R5: When credit plus the current coin reaches 20 units or more, `vend_o` is 1 in that same cycle, and `change_o` equals (credit + coin - 20) / 5.
- R6: `change_o` is 0 in every cycle where `vend_o` is 0.
- R7: After a vend cycle the credit is zero, with no remainder carried into the next purchase.
- R8: A credit of 15 units plus a 25-unit coin vends with `change_o` = 4 (20 units), the largest change value.
- R9: After `rst_n_i` rises, coins presented before the second rising edge are ignored. Coins presented from then on are counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| coin_valid_i | input | 1 | Coin strobe, one coin per high cycle |
| coin_code_i | input | 2 | Coin type: 00 none, 01 = 5, 10 = 10, 11 = 25 units |
| vend_o | output | 1 | One-cycle dispense pulse (Mealy) |
| change_o | output | 3 | Change owed in 5-unit steps, valid while vend_o is high |

## Verification
`vend_o` and `change_o` depend combinationally on the stored credit and the coin on the inputs, so each result belongs to the cycle in which its coin is driven. The credit a coin adds only shows in how the next coin is answered, one rising edge later. The bench drives each coin just after a rising edge and samples the outputs at the following falling edge. The credit update is therefore checked through the response to the next coin. The reset release check counts exactly two rising edges after `rst_n_i` rises before it expects coins to be counted.

// File: rtl/vend_pkg.sv
package vend_pkg;
  // price and coin values in units of the smallest coin (5 units)
  localparam int unsigned PRICE_STEPS    = 4;
  localparam int unsigned COIN_LO_STEPS  = 1;
  localparam int unsigned COIN_MID_STEPS = 2;
  localparam int unsigned COIN_HI_STEPS  = 5;

  localparam int unsigned CREDIT_W = $clog2(PRICE_STEPS);
  localparam int unsigned MAX_SUM  = PRICE_STEPS - 1 + COIN_HI_STEPS;
  localparam int unsigned SUM_W    = $clog2(MAX_SUM + 1);
  localparam int unsigned CHG_MAX  = MAX_SUM - PRICE_STEPS;
  localparam int unsigned CHG_W    = $clog2(CHG_MAX + 1);

  typedef enum logic [1:0] {
    COIN_NONE = 2'b00,
    COIN_LO   = 2'b01,
    COIN_MID  = 2'b10,
    COIN_HI   = 2'b11
  } coin_e;

  typedef logic [CREDIT_W-1:0] credit_t;
  typedef logic [SUM_W-1:0]    sum_t;
  typedef logic [CHG_W-1:0]    chg_t;

  typedef struct packed {
    logic    vend;
    chg_t    change;
    credit_t credit_nxt;
  } step_t;
endpackage

// File: rtl/vend_rst_sync.sv
module vend_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_n_i,
  output logic srst_n_o
);
  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge arst_n_i) begin
        if (!arst_n_i) sync_q <= '0;
        else           sync_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge arst_n_i) begin
        if (!arst_n_i) sync_q <= '0;
        else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign srst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/vend_coin_value.sv
module vend_coin_value
  import vend_pkg::*;
(
  input  logic [1:0] code_i,
  output sum_t       steps_o
);
  always_comb begin
    unique case (coin_e'(code_i))
      COIN_LO:  steps_o = SUM_W'(COIN_LO_STEPS);
      COIN_MID: steps_o = SUM_W'(COIN_MID_STEPS);
      COIN_HI:  steps_o = SUM_W'(COIN_HI_STEPS);
      default:  steps_o = '0;
    endcase
  end
endmodule

// File: rtl/vend_step_logic.sv
module vend_step_logic
  import vend_pkg::*;
(
  input  logic    active_i,
  input  credit_t credit_i,
  input  sum_t    coin_steps_i,
  output step_t   step_o
);
  sum_t total;
  sum_t surplus;

  always_comb begin
    total   = SUM_W'(credit_i) + coin_steps_i;
    surplus = total - SUM_W'(PRICE_STEPS);
    step_o  = '{vend: 1'b0, change: '0, credit_nxt: credit_i};
    if (active_i) begin
      if (total >= SUM_W'(PRICE_STEPS)) begin
        step_o.vend       = 1'b1;
        step_o.change     = CHG_W'(surplus);
        step_o.credit_nxt = '0;
      end else begin
        step_o.credit_nxt = CREDIT_W'(total);
      end
    end
  end
endmodule

// File: rtl/vend_credit_reg.sv
module vend_credit_reg
  import vend_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_n_i,
  input  logic    en_i,
  input  credit_t d_i,
  output credit_t q_o
);
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)  q_o <= '0;
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/coin_vend_fsm.sv
module coin_vend_fsm
  import vend_pkg::*;
#(
  parameter int unsigned RST_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             coin_valid_i,
  input  logic [1:0]       coin_code_i,
  output logic             vend_o,
  output logic [CHG_W-1:0] change_o
);
  logic    srst_n;
  logic    active;
  logic    credit_en;
  sum_t    coin_steps;
  credit_t credit_q;
  step_t   step;

  vend_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk_i    (clk_i),
    .arst_n_i (rst_n_i),
    .srst_n_o (srst_n)
  );

  vend_coin_value u_coin_value (
    .code_i  (coin_code_i),
    .steps_o (coin_steps)
  );

  assign active = srst_n & coin_valid_i;

  vend_step_logic u_step (
    .active_i     (active),
    .credit_i     (credit_q),
    .coin_steps_i (coin_steps),
    .step_o       (step)
  );

  // clock enable: only a counted, non-empty coin moves the credit
  assign credit_en = active & (coin_steps != '0);

  vend_credit_reg u_credit (
    .clk_i   (clk_i),
    .rst_n_i (srst_n),
    .en_i    (credit_en),
    .d_i     (step.credit_nxt),
    .q_o     (credit_q)
  );

  assign vend_o   = step.vend;
  assign change_o = step.change;
endmodule

// File: rtl/coin_vend_fsm_chk.sv
module coin_vend_fsm_chk
  import vend_pkg::*;
(
  input logic             clk_i,
  input logic             rst_n_i,
  input logic             coin_valid_i,
  input logic [1:0]       coin_code_i,
  input logic             vend_o,
  input logic [CHG_W-1:0] change_o,
  input credit_t          credit_q
);
  // R1: outputs quiet while reset is held
  always @(negedge clk_i) begin
    if (!rst_n_i) begin
      p_reset_quiet_r1: assert (!vend_o && change_o == '0)
        else $error("reset: vend or change active");
    end
  end

  // R2: a vend needs a real coin in the same cycle
  p_vend_needs_coin_r2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    vend_o |-> (coin_valid_i && coin_code_i != 2'b00));

  // R3: credit held when no coin strobe
  p_credit_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !coin_valid_i |=> $stable(credit_q));

  // R6: change quiet without vend
  p_change_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !vend_o |-> change_o == '0);

  // R7: credit cleared after a vend
  p_clear_after_vend_r7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    vend_o |=> credit_q == '0);

  // R8: change never beyond the largest overpayment
  p_change_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    vend_o |-> change_o <= CHG_W'(CHG_MAX));
endmodule

bind coin_vend_fsm coin_vend_fsm_chk u_chk (
  .clk_i        (clk_i),
  .rst_n_i      (rst_n_i),
  .coin_valid_i (coin_valid_i),
  .coin_code_i  (coin_code_i),
  .vend_o       (vend_o),
  .change_o     (change_o),
  .credit_q     (credit_q)
);

// File: tb/test_coin_vend_fsm.sv
`timescale 1ns/1ps
module test_coin_vend_fsm;
  logic       clk;
  logic       rst_n;
  logic       coin_valid;
  logic [1:0] coin_code;
  logic       vend;
  logic [2:0] change;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  coin_vend_fsm i_coin_vend_fsm (
    .clk_i        (clk),
    .rst_n_i      (rst_n),
    .coin_valid_i (coin_valid),
    .coin_code_i  (coin_code),
    .vend_o       (vend),
    .change_o     (change)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // entry: {valid, code[1:0], exp_vend, exp_change[2:0]}, applied from zero credit
  localparam int NVEC = 24;
  localparam logic [6:0] VEC [NVEC] = '{
    7'b1_01_0_000, 7'b1_01_0_000, 7'b1_01_0_000, 7'b1_01_1_000,
    7'b1_10_0_000, 7'b1_10_1_000, 7'b1_11_1_001, 7'b1_01_0_000,
    7'b1_11_1_010, 7'b1_10_0_000, 7'b0_11_0_000, 7'b1_00_0_000,
    7'b1_11_1_011, 7'b1_01_0_000, 7'b1_10_0_000, 7'b1_11_1_100,
    7'b1_10_0_000, 7'b1_01_0_000, 7'b1_10_1_001, 7'b0_01_0_000,
    7'b1_01_0_000, 7'b1_01_0_000, 7'b1_01_0_000, 7'b1_10_1_001
  };

  task automatic check(input string req, input logic act_v, input logic exp_v,
                       input logic [2:0] act_c, input logic [2:0] exp_c);
    checks++;
    if (act_v !== exp_v || act_c !== exp_c) begin
      failures++;
      $display("FAIL %s: vend=%0b change=%0d expected vend=%0b change=%0d",
               req, act_v, act_c, exp_v, exp_c);
    end
  endtask

  // drive just after a rising edge, sample on the falling edge
  task automatic apply(input logic v, input logic [1:0] c);
    @(posedge clk);
    #1;
    coin_valid = v;
    coin_code  = c;
    @(negedge clk);
  endtask

  task automatic release_reset();
    @(posedge clk);
    #1;
    rst_n = 1'b1;
  endtask

  initial begin
    rst_n      = 1'b0;
    coin_valid = 1'b0;
    coin_code  = 2'b00;
    repeat (3) @(posedge clk);

    // R1: coin during reset has no effect
    apply(1'b1, 2'b11);
    check("R1", vend, 1'b0, change, 3'd0);
    apply(1'b0, 2'b00);
    release_reset();
    repeat (3) @(posedge clk);

    // vector walk
    for (int i = 0; i < NVEC; i++) begin
      string tag;
      apply(VEC[i][6], VEC[i][5:4]);
      if (!VEC[i][6])                 tag = "R3";
      else if (VEC[i][5:4] == 2'b00)  tag = "R2";
      else if (VEC[i][2:0] == 3'd4)   tag = "R8";
      else if (VEC[i][3])             tag = "R5";
      else                            tag = "R4";
      check(tag, vend, VEC[i][3], change, VEC[i][2:0]);
      if (!VEC[i][3]) check("R6", vend, 1'b0, change, 3'd0);
    end

    // R7: 15 + 10 vends, next 10 does not vend (no remainder kept)
    apply(1'b1, 2'b10);
    apply(1'b1, 2'b01);
    apply(1'b1, 2'b10);
    check("R7", vend, 1'b1, change, 3'd1);
    apply(1'b1, 2'b10);
    check("R7", vend, 1'b0, change, 3'd0);
    apply(1'b1, 2'b10);
    check("R7", vend, 1'b1, change, 3'd0);

    // R1: reset mid-transaction clears 15 units of credit
    apply(1'b1, 2'b11);
    apply(1'b1, 2'b01);
    apply(1'b1, 2'b10);
    apply(1'b0, 2'b00);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", vend, 1'b0, change, 3'd0);

    // R9: two edges after release before coins count
    release_reset();
    coin_valid = 1'b1;
    coin_code  = 2'b11;
    @(negedge clk);
    check("R9", vend, 1'b0, change, 3'd0);
    apply(1'b1, 2'b11);
    check("R9", vend, 1'b0, change, 3'd0);
    apply(1'b1, 2'b11);
    check("R9", vend, 1'b1, change, 3'd1);
    // R1: credit was zero after reset: 10 then 5 then 5 vends exactly
    apply(1'b1, 2'b10);
    check("R1", vend, 1'b0, change, 3'd0);
    apply(1'b1, 2'b01);
    apply(1'b1, 2'b01);
    check("R1", vend, 1'b1, change, 3'd0);
    apply(1'b0, 2'b00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule